// File: doc/BRIEF.md
# Four-Lane ADC DC Offset Corrector

This block takes one beat per transfer carrying four signed 16-bit ADC samples. The lanes are the in-phase and quadrature samples of two receive sides. From each sample it subtracts an offset and saturates the result, so the output is never wrapped. It returns the corrected beat one register stage later.

Each lane picks its offset source from its own loop-enable bit:
- With the bit clear, the lane subtracts an offset that the host writes.
- With the bit set, the lane subtracts an estimate that a first-order tracking loop keeps. The loop feeds each corrected output back into a fractional accumulator, so a constant input is driven toward zero.

Both sides of the datapath use valid/ready. A beat is transferred on a rising edge where valid and ready are both high. The upstream ready is high whenever the output register is empty or is being drained in the same cycle. While the output is stalled, the output beat and all tracking state hold still. Configuration comes through a plain write port. It has no handshake and is accepted on any cycle where the write enable is high.

Top module: `dcoff_unit`

## Requirements
- R1: After reset all four loop-enable bits are 1, every host offset and every tracking accumulator is 0, `m_valid` is 0 and `s_ready` is 1.
- R2: Lane k occupies bits [16k+15:16k] of `s_data` and `m_data`. Lane 0 is side A in-phase, lane 1 side A quadrature, lane 2 side B in-phase and lane 3 side B quadrature. A write to `cfg_addr` k (0..3) sets the host offset of lane k from `cfg_wdata` as a signed value.
- R3: A lane whose loop-enable bit is 0 outputs the input sample minus that lane's host offset.
- R4: Each subtraction saturates to the range -32768..32767 instead of wrapping.
- R5: A lane whose loop-enable bit is 1 subtracts its estimate. The estimate is the accumulator arithmetically shifted right by SHIFT (default 10) bits. Each accepted beat adds that lane's corrected output to its accumulator, after the output has been formed.
- R6: A lane whose loop-enable bit is 0 leaves its accumulator unchanged. When the bit is set again, tracking resumes from the held value.
- R7: A write to `cfg_addr` 4 updates loop-enable bit k to `cfg_wdata[k]` only where `cfg_wmask[k]` is 1. The other enable bits are kept, and `cfg_wdata` bits 15:4 are ignored.
- R8: A beat accepted on one rising edge appears on `m_data` with `m_valid` high right after that edge. With no beat accepted and the output drained, `m_valid` is 0.
- R9: `s_ready` equals `!m_valid || m_ready`. While `m_valid` is high and `m_ready` is low, `m_data` holds its value and `m_valid` stays high.
- R10: A configuration write affects only beats accepted on later edges. A write to an address of 5 to 7 changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Input beat valid |
| s_ready | output | 1 | Block can take an input beat |
| s_data | input | 64 | Four signed raw samples, lane 0 in low bits |
| m_valid | output | 1 | Output beat valid |
| m_ready | input | 1 | Downstream takes the output beat |
| m_data | output | 64 | Four signed corrected samples, lane 0 in low bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_addr | input | 3 | 0..3 lane host offset, 4 loop enables |
| cfg_wdata | input | 16 | Write value |
| cfg_wmask | input | 4 | Per-lane mask for the loop-enable write |

## Verification
The bench goes after the saturation corners: the largest positive sample with the most negative offset, and the reverse. A design that wraps would give the opposite sign.

It runs a loop for thousands of beats on a constant input. An accumulator that is scaled wrongly, updated before the output is formed, or updated while the lane is disabled would make the outputs drift away from the model. A partial-mask enable write would show a design that ignores the mask, because lanes that should keep direct subtraction would start tracking.

Random downstream stalls check that nothing is lost or duplicated and that outputs hold. A stall that leaks into the accumulator would show as a wrong value later on.

// File: rtl/dcoff_pkg.sv
package dcoff_pkg;
  // lane index meaning; the order is what the host programs against
  typedef enum int {
    LANE_A_I = 0,
    LANE_A_Q = 1,
    LANE_B_I = 2,
    LANE_B_Q = 3
  } lane_id_e;

  localparam int DEF_LANES = 4;
  localparam int DEF_WIDTH = 16;
  localparam int DEF_SHIFT = 10;
endpackage

// File: rtl/dcoff_regs.sv
module dcoff_regs #(
  parameter int NCH = 4,
  parameter int W   = 16,
  parameter int AW  = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [W-1:0]     cfg_wdata,
  input  logic [NCH-1:0]   cfg_wmask,
  output logic [NCH*W-1:0] host_off,
  output logic [NCH-1:0]   loop_en
);
  localparam logic [AW-1:0] EN_ADDR = AW'(NCH);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loop_en <= '1;
    end else if (cfg_we && cfg_addr == EN_ADDR) begin
      loop_en <= (loop_en & ~cfg_wmask) | (cfg_wdata[NCH-1:0] & cfg_wmask);
    end
  end

  for (genvar k = 0; k < NCH; k++) begin : g_off
    always_ff @(posedge clk) begin
      if (!rst_n) host_off[k*W +: W] <= '0;
      else if (cfg_we && cfg_addr == AW'(k)) host_off[k*W +: W] <= cfg_wdata;
    end
  end

  // masked-off enable bits never move on an enable write
  assert_mask_keep_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we && cfg_addr == EN_ADDR) |=> ((loop_en ^ $past(loop_en)) & ~$past(cfg_wmask)) == '0);

  // without a write nothing in the register set changes
  assert_no_spurious_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_we |=> ($stable(loop_en) && $stable(host_off)));
endmodule

// File: rtl/dcoff_lane.sv
module dcoff_lane #(
  parameter int W     = 16,
  parameter int SHIFT = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         take,
  input  logic [W-1:0] x,
  input  logic [W-1:0] host_off,
  input  logic         loop_en,
  output logic [W-1:0] y
);
  localparam int AW = W + SHIFT;
  localparam logic [W-1:0] POS_MAX = {1'b0, {(W-1){1'b1}}};
  localparam logic [W-1:0] NEG_MAX = {1'b1, {(W-1){1'b0}}};

  logic [AW-1:0] acc;
  logic [W-1:0]  est, off;
  logic [W:0]    diff;
  logic [AW:0]   sum;

  assign est  = acc[AW-1:SHIFT];
  assign off  = loop_en ? est : host_off;
  assign diff = {x[W-1], x} - {off[W-1], off};

  always_comb begin
    if (diff[W] != diff[W-1]) y = diff[W] ? NEG_MAX : POS_MAX;
    else                      y = diff[W-1:0];
  end

  assign sum = {acc[AW-1], acc} + {{(SHIFT+1){y[W-1]}}, y};

  always_ff @(posedge clk) begin
    if (!rst_n)              acc <= '0;
    else if (take && loop_en) acc <= sum[AW-1:0];
  end

  // bounded feedback: the accumulator add never leaves its range
  assert_acc_in_range_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && loop_en) |-> (sum[AW] == sum[AW-1]));

  assert_hold_est_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !loop_en |=> $stable(acc));

  assert_no_wrap_pos_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!x[W-1] && off[W-1]) |-> !y[W-1]);

  assert_no_wrap_neg_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (x[W-1] && !off[W-1]) |-> y[W-1]);
endmodule

// File: rtl/dcoff_unit.sv
module dcoff_unit #(
  parameter int NCH   = dcoff_pkg::DEF_LANES,
  parameter int W     = dcoff_pkg::DEF_WIDTH,
  parameter int SHIFT = dcoff_pkg::DEF_SHIFT,
  parameter int AW    = $clog2(NCH) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [NCH*W-1:0] s_data,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [NCH*W-1:0] m_data,
  input  logic             cfg_we,
  input  logic [AW-1:0]    cfg_addr,
  input  logic [W-1:0]     cfg_wdata,
  input  logic [NCH-1:0]   cfg_wmask
);
  logic [NCH*W-1:0] host_off;
  logic [NCH-1:0]   loop_en;
  logic [NCH*W-1:0] corr;
  logic             take;

  assign s_ready = !m_valid || m_ready;
  assign take    = s_valid && s_ready;

  dcoff_regs #(.NCH(NCH), .W(W), .AW(AW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_wmask(cfg_wmask),
    .host_off(host_off), .loop_en(loop_en)
  );

  for (genvar k = 0; k < NCH; k++) begin : g_lane
    dcoff_lane #(.W(W), .SHIFT(SHIFT)) u_lane (
      .clk(clk), .rst_n(rst_n), .take(take),
      .x(s_data[k*W +: W]), .host_off(host_off[k*W +: W]), .loop_en(loop_en[k]),
      .y(corr[k*W +: W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m_valid <= 1'b0;
      m_data  <= '0;
    end else if (s_ready) begin
      m_valid <= s_valid;
      if (s_valid) m_data <= corr;
    end
  end

  assert_valid_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (s_valid && s_ready) |=> m_valid);

  assert_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && $stable(m_data)));

  assert_ready_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |-> !s_ready);
endmodule

// File: tb/dcoff_unit_test.sv
module dcoff_unit_test;
  localparam int SHIFT = 10;
  logic clk = 0, rst_n = 0;
  logic s_valid = 0, m_ready = 1, cfg_we = 0;
  logic s_ready, m_valid;
  logic [63:0] s_data = '0, m_data;
  logic [2:0]  cfg_addr = '0;
  logic [15:0] cfg_wdata = '0;
  logic [3:0]  cfg_wmask = '0;

  int checks = 0, errors = 0;
  bit stall_en = 0, done = 0;
  logic [15:0] lfsr = 16'hACE1;

  longint m_acc[4];
  longint m_hoff[4];
  bit     m_en[4];
  logic [63:0] exp_q[$];
  string       tag_q[$];

  always #10 clk = ~clk;

  dcoff_unit uut (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready), .s_data(s_data),
    .m_valid(m_valid), .m_ready(m_ready), .m_data(m_data),
    .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_wmask(cfg_wmask)
  );

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // downstream ready pattern
  always @(negedge clk) begin
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    m_ready = stall_en ? (lfsr[0] | lfsr[3]) : 1'b1;
  end

  // monitor: pop and compare on every transfer; check hold during stalls
  bit prev_stall = 0;
  logic [63:0] prev_data;
  always @(negedge clk) begin
    #2;
    if (rst_n) begin
      if (prev_stall) chk(m_valid && m_data == prev_data, "R9 hold", m_data, prev_data);
      if (m_valid && m_ready) begin
        if (exp_q.size() == 0) chk(0, "R8 unexpected beat", m_data, 0);
        else begin
          logic [63:0] e;
          string t;
          e = exp_q.pop_front();
          t = tag_q.pop_front();
          chk(m_data == e, t, m_data, e);
        end
      end
      prev_stall = m_valid && !m_ready;
      prev_data  = m_data;
    end
  end

  function automatic longint sat16(input longint v);
    if (v > 32767) return 32767;
    if (v < -32768) return -32768;
    return v;
  endfunction

  task automatic send(input int x0, input int x1, input int x2, input int x3, input string tag);
    int xs[4];
    logic [63:0] e;
    xs = '{x0, x1, x2, x3};
    @(negedge clk);
    s_valid = 1;
    for (int k = 0; k < 4; k++) s_data[k*16 +: 16] = 16'(xs[k]);
    #1;
    while (!s_ready) begin @(negedge clk); #1; end
    for (int k = 0; k < 4; k++) begin
      longint off, y;
      off = m_en[k] ? (m_acc[k] >>> SHIFT) : m_hoff[k];
      y = sat16(longint'(xs[k]) - off);
      e[k*16 +: 16] = 16'(y);
      if (m_en[k]) m_acc[k] += y;
    end
    exp_q.push_back(e);
    tag_q.push_back(tag);
    @(posedge clk);
  endtask

  task automatic idle();
    @(negedge clk);
    s_valid = 0;
  endtask

  task automatic drain();
    idle();
    while (exp_q.size() != 0) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic cfg(input int addr, input int data, input int mask);
    @(negedge clk);
    s_valid = 0;
    cfg_we = 1; cfg_addr = 3'(addr); cfg_wdata = 16'(data); cfg_wmask = 4'(mask);
    if (addr < 4) m_hoff[addr] = longint'($signed(16'(data)));
    else if (addr == 4)
      for (int k = 0; k < 4; k++) if (mask[k]) m_en[k] = data[k];
    @(negedge clk);
    cfg_we = 0;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < 4; k++) begin m_acc[k] = 0; m_hoff[k] = 0; m_en[k] = 1; end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #3;
    chk(m_valid == 0, "R1 m_valid after reset", m_valid, 0);
    chk(s_ready == 1, "R1 s_ready after reset", s_ready, 1);

    // R1/R5: loops enabled by default, distinct lane values (R2 order)
    for (int i = 0; i < 6; i++) send(1000, -500, 77, -3000, "R5 default tracking");
    drain();

    // R8: single beat latency
    send(5, 6, 7, 8, "R8 single beat");
    @(negedge clk); #3;
    chk(m_valid == 1, "R8 valid one stage later", m_valid, 1);
    s_valid = 0;
    drain();
    #3 chk(m_valid == 0, "R8 idle output", m_valid, 0);

    // R3/R2: host offsets, loops off
    cfg(0, 100, 0); cfg(1, -200, 0); cfg(2, 300, 0); cfg(3, -400, 0);
    cfg(4, 0, 4'hF);
    send(1000, 1000, 1000, 1000, "R3 host offset per lane");
    send(-5, 0, 12345, -12345, "R2 lane order");
    drain();

    // R4: saturation both directions
    cfg(0, 16'h8000, 0); cfg(1, 16'h7FFF, 0);
    send(32767, -32768, 0, 0, "R4 saturate");
    send(-32768, 32767, 0, 0, "R4 no saturate");
    drain();

    // R7: partial mask; upper data bits ignored
    cfg(4, 16'hFFF5, 4'b0101);
    for (int i = 0; i < 4; i++) send(2000, 2000, 2000, 2000, "R7 masked enable");
    drain();

    // R10: unused address changes nothing
    cfg(5, 16'h7777, 4'hF); cfg(6, 16'h1234, 4'hF);
    send(2000, 2000, 2000, 2000, "R10 ignored address");

    // R5 long convergence, R6 hold then resume
    cfg(4, 4'hF, 4'hF);
    for (int i = 0; i < 3000; i++) send(1500, -900, 20000, -32768, "R5 convergence");
    cfg(4, 0, 4'b0011);
    for (int i = 0; i < 20; i++) send(1500, -900, 20000, -32768, "R6 disabled");
    cfg(4, 4'b0011, 4'b0011);
    for (int i = 0; i < 20; i++) send(1500, -900, 20000, -32768, "R6 resume");
    drain();

    // R9: random back-pressure
    stall_en = 1;
    for (int i = 0; i < 300; i++) send(i * 37 - 5000, -i, i * 101, 3 - i, "R9 stalled stream");
    drain();
    stall_en = 0;
    drain();
    chk(exp_q.size() == 0, "R9 nothing lost", exp_q.size(), 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule